// File: doc/BRIEF.md
# Mode-Selectable Adder with Overflow Flag

This block is an n-bit ripple-carry arithmetic unit (4 bits by default). A 2-bit operation select picks one of four operations that all run through the same full-adder chain: unsigned addition, signed addition, signed subtraction, and two's-complement negation of operand b. Subtraction and negation feed the inverted b operand into the chain and force the chain's carry-in to 1. Negation also replaces operand a with zero.

The result, the raw carry out of the top adder stage and a single overflow flag are produced every cycle. The flag's meaning follows the selected operation:

- In unsigned addition it reports the carry out.
- In the two signed arithmetic modes it reports a sign flip between operands of equal sign.
- In negation it reports that b holds the most negative value, which has no positive counterpart.

A parameter adds an optional output register. It is cleared by an asynchronous active-low reset and delays all three outputs by one clock.

Top module: `mode_adder`

## Requirements
- R1: With op_sel = 2'b00 or 2'b01, result equals (op_a + op_b + carry_in) mod 2^WIDTH and carry_out equals bit WIDTH of that sum.
- R2: With op_sel = 2'b00 (unsigned add), overflow equals carry_out.
- R3: With op_sel = 2'b01 (signed add), overflow is 1 exactly when the two's-complement value op_a + op_b + carry_in lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1.
- R4: With op_sel = 2'b01, overflow is never 1 when the MSBs of op_a and op_b differ.
- R5: With op_sel = 2'b10 (signed subtract), result equals (op_a - op_b) mod 2^WIDTH, carry_out equals bit WIDTH of op_a + ~op_b + 1 (1 when op_a >= op_b unsigned), and carry_in has no effect.
- R6: With op_sel = 2'b10, overflow is 1 exactly when the signed difference op_a - op_b lies outside the signed range.
- R7: With op_sel = 2'b11 (negate b), result equals (-op_b) mod 2^WIDTH and carry_out is 1 exactly when op_b is zero; op_a and carry_in have no effect.
- R8: With op_sel = 2'b11, overflow is 1 exactly when op_b is the most negative value (MSB 1, all other bits 0).
- R9: With REGISTER_OUT = 1, all three outputs read 0 while rst_n is low and otherwise show the combinational values one clock after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 2 | Operation: 00 unsigned add, 01 signed add, 10 signed subtract, 11 negate b |
| carry_in | input | 1 | Carry into the chain in the two addition modes |
| result | output | WIDTH | Arithmetic result |
| carry_out | output | 1 | Carry out of the top adder stage |
| overflow | output | 1 | Mode-dependent overflow flag |

## Verification
Carry-out and overflow can be raised together in one result: a carry leaving the top stage while the signed interpretation also wraps. Examples are adding two negative operands past the most negative value, or negating zero, which produces a carry while overflow must stay clear. Every operand, carry-in and operation combination is applied for a 4-bit width. The bench judges the result, carry_out and overflow separately against integer arithmetic computed in the bench. For the overflow flag the relevant reference is the unsigned carry or the signed range test, chosen by mode. Directed corner vectors then repeat the cases where the two flags agree or disagree, on the registered variant as well.

// File: rtl/mode_adder.sv
module mode_adder #(
  parameter int WIDTH        = 4,
  parameter bit REGISTER_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       op_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;
  localparam logic [1:0] SEL_UADD = 2'b00;
  localparam logic [1:0] SEL_SADD = 2'b01;
  localparam logic [1:0] SEL_SSUB = 2'b10;
  localparam logic [1:0] SEL_NEGB = 2'b11;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] add_x, add_y, sum_w;
  logic [WIDTH:0]   chain;
  logic             ovf_w;

  // operand conditioning: subtract and negate invert b and inject a carry
  assign add_x    = (op_sel == SEL_NEGB) ? '0 : op_a;
  assign add_y    = op_sel[1] ? ~op_b : op_b;
  assign chain[0] = op_sel[1] ? 1'b1 : carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign sum_w[i]   = add_x[i] ^ add_y[i] ^ chain[i];
    assign chain[i+1] = (add_x[i] & add_y[i]) | (chain[i] & (add_x[i] ^ add_y[i]));
  end

  always_comb begin
    unique case (op_sel)
      SEL_UADD: ovf_w = chain[WIDTH];
      SEL_SADD,
      SEL_SSUB: ovf_w = (add_x[MSB] ~^ add_y[MSB]) & (add_y[MSB] ^ sum_w[MSB]);
      default:  ovf_w = (op_b == MOST_NEG);
    endcase
  end

  if (REGISTER_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result    <= '0;
        carry_out <= 1'b0;
        overflow  <= 1'b0;
      end else begin
        result    <= sum_w;
        carry_out <= chain[WIDTH];
        overflow  <= ovf_w;
      end
    end

    assert_reg_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (result == $past(sum_w)) && (overflow == $past(ovf_w)));
  end else begin : g_comb
    assign result    = sum_w;
    assign carry_out = chain[WIDTH];
    assign overflow  = ovf_w;
  end

  assert_uadd_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == SEL_UADD) |->
      ({chain[WIDTH], sum_w} == ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == SEL_SADD && (op_a[MSB] != op_b[MSB])) |-> !ovf_w);

  assert_sub_diff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == SEL_SSUB) |-> (sum_w == WIDTH'(op_a - op_b)));

  assert_neg_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == SEL_NEGB) |-> (sum_w == WIDTH'(-op_b)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == SEL_NEGB && op_b != MOST_NEG) |-> !ovf_w);
endmodule

// File: tb/test_mode_adder.sv
module test_mode_adder;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic [1:0]   sel = 2'b00;
  logic         cin = 1'b0;
  logic [N-1:0] res, res_q;
  logic         co, co_q, ov, ov_q;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mode_adder #(.WIDTH(N), .REGISTER_OUT(1'b0)) i_mode_adder (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .op_sel(sel), .carry_in(cin),
    .result(res), .carry_out(co), .overflow(ov));

  mode_adder #(.WIDTH(N), .REGISTER_OUT(1'b1)) i_mode_adder_q (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .op_sel(sel), .carry_in(cin),
    .result(res_q), .carry_out(co_q), .overflow(ov_q));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d sel=%0d cin=%0d got=%0d exp=%0d", tag, a, b, sel, cin, got, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= M/2) ? v - M : v;
  endfunction

  // reference model: {result, carry, overflow} from integer arithmetic
  task automatic expect_vals(input int av, input int bv, input int s, input int ci,
                             output int er, output int ec, output int eo);
    int tot, st;
    case (s)
      0: begin tot = av + bv + ci; eo = (tot >= M) ? 1 : 0; end
      1: begin tot = av + bv + ci; st = sgn(av) + sgn(bv) + ci;
               eo = (st > M/2-1 || st < -M/2) ? 1 : 0; end
      2: begin tot = av + (M-1-bv) + 1; st = sgn(av) - sgn(bv);
               eo = (st > M/2-1 || st < -M/2) ? 1 : 0; end
      default: begin tot = (M-1-bv) + 1; st = -sgn(bv);
               eo = (st > M/2-1) ? 1 : 0; end
    endcase
    er = tot % M;
    ec = (tot >= M) ? 1 : 0;
  endtask

  task automatic apply_check(input int av, input int bv, input int s, input int ci);
    int er, ec, eo;
    @(negedge clk);
    a = N'(av); b = N'(bv); sel = 2'(s); cin = ci[0];
    #1;
    expect_vals(av, bv, s, ci, er, ec, eo);
    case (s)
      0: begin check("R1 result", res, er); check("R1 carry", co, ec); check("R2 overflow", ov, eo); end
      1: begin check("R1 result", res, er); check("R1 carry", co, ec);
               if (av[N-1] != bv[N-1]) check("R4 overflow", ov, 0);
               else check("R3 overflow", ov, eo); end
      2: begin check("R5 result", res, er); check("R5 carry", co, ec); check("R6 overflow", ov, eo); end
      default: begin check("R7 result", res, er); check("R7 carry", co, ec); check("R8 overflow", ov, eo); end
    endcase
  endtask

  task automatic test_reset;
    check("R9 reset result", res_q, 0);
    check("R9 reset carry", co_q, 0);
    check("R9 reset overflow", ov_q, 0);
  endtask

  task automatic test_sweep(input int s);
    for (int ci = 0; ci < 2; ci++)
      for (int av = 0; av < M; av++)
        for (int bv = 0; bv < M; bv++)
          apply_check(av, bv, s, ci);
  endtask

  task automatic test_corners;
    apply_check(8, 8, 1, 0);   // both negative, wraps: carry and overflow together
    apply_check(7, 0, 1, 1);   // carry-in pushes past max positive
    apply_check(8, 7, 1, 1);   // opposite signs, R4
    apply_check(0, 8, 3, 1);   // negate most negative, R8
    apply_check(15, 0, 3, 1);  // negate zero: carry without overflow, R7
    apply_check(8, 1, 2, 1);   // most negative minus one, R6
    apply_check(7, 8, 2, 0);   // max positive minus most negative, R6
  endtask

  task automatic test_ignored;
    int r0, c0, o0;
    apply_check(3, 5, 2, 0);
    r0 = res; c0 = co; o0 = ov;
    apply_check(3, 5, 2, 1);
    check("R5 cin ignored result", res, r0); check("R5 cin ignored carry", co, c0);
    check("R5 cin ignored overflow", ov, o0);
    apply_check(0, 6, 3, 0);
    r0 = res; c0 = co;
    apply_check(13, 6, 3, 1);
    check("R7 a/cin ignored result", res, r0); check("R7 a/cin ignored carry", co, c0);
  endtask

  task automatic test_registered;
    int er, ec, eo;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a = N'(k*5 + 2); b = N'(k*3 + 8); sel = 2'(k); cin = k[0];
      expect_vals(k*5 + 2, (k*3 + 8) % M, k, k % 2, er, ec, eo);
      @(negedge clk);
      check("R9 registered result", res_q, er);
      check("R9 registered carry", co_q, ec);
      check("R9 registered overflow", ov_q, eo);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) test_sweep(s);
    test_corners();
    test_ignored();
    test_registered();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule